// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block reprograms one PLL out of a group of five. A request gives the PLL index and three divisor values: the reference divider NR, the feedback multiplier NF and the output divider NO. The block first confirms that the divisors are legal. It then steps through a fixed sequence of masked register writes. The sequence places the PLL in slow mode and holds the PLL in reset while the divisors are loaded. It keeps reset for a fixed number of microsecond ticks, releases it, and waits for the PLL's lock status bit. After lock it returns the PLL to normal mode. The block reports the end of every request with a one-cycle `done` pulse, and `err` flags any request that failed.

Every write leaves the block through one of two masked write ports. One port serves the four control words of the selected PLL. The other serves the shared mode word, which holds a 2-bit field for each PLL. A 16-bit status word carries one lock bit per PLL. A one-cycle pulse on `us_tick` supplies the time base.

The state machine has these states:
- IDLE: accepts a request.
- CHECK: judges the request.
- SLOW: writes the mode field to slow.
- RST_ON: sets the reset bit.
- WR_NR_NO: writes control word 0.
- WR_NF: writes control word 1.
- WR_BW: writes control word 2.
- HOLD: counts ticks with reset held.
- RST_OFF: clears the reset bit.
- POLL: waits for lock.
- NORMAL: writes the mode field to normal.
- DONE: pulses `done`.
- FAIL: pulses `done` together with `err`.

The transitions are:
- IDLE→CHECK on a request.
- CHECK→FAIL on an illegal request, otherwise CHECK→SLOW.
- SLOW→RST_ON→WR_NR_NO→WR_NF→WR_BW→HOLD, one state per cycle.
- HOLD→RST_OFF once the tick count reaches the hold length.
- RST_OFF→POLL.
- POLL→NORMAL on lock.
- POLL→FAIL when the timeout expires.
- NORMAL→DONE.
- DONE→IDLE and FAIL→IDLE.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low, and neither write port is active while `busy` is low.
- R2: A request is rejected with `done` and `err` together, two cycles after acceptance, and with no register write, in any of these cases:
  - Reference × NF / NR lies outside 440–2200 MHz (the reference is 24 MHz).
  - That VCO frequency divided by NO lies outside 27.5–2200 MHz.
  - NO is neither 1 nor even.
  - NR is outside 1..64, NF is outside 2..8192, NO is outside 1..16, or the index is 5 or more.
- R3: An accepted legal request produces exactly these writes, one per cycle and in this order:
  - mode slow
  - reset on
  - control word 0
  - control word 1
  - control word 2
  - reset off
  - mode normal
- R4: Each mode write touches only the 2-bit field of its PLL. The field sits at bit 0, 4, 8, 12 or 14 for PLL 0 to 4. Slow is code 0 and normal is code 1.
- R5: Control word 0 carries NR−1 in bits 13:8 and NO−1 in bits 3:0, with mask 0x3F0F. Control word 1 carries NF−1 in bits 12:0, with mask 0x1FFF.
- R6: Control word 2 carries the bandwidth value floor(NF/2)−1 in bits 11:0, with mask 0x0FFF.
- R7: The reset bit is bit 5 of control word 3, written with mask 0x0020. It is set before any divisor write and cleared after the divisor writes.
- R8: Between the control word 2 write and the reset-off write, exactly 10 `us_tick` pulses are counted.
- R9: After reset release the block waits for status bit 5+index. It writes normal mode only after seeing that bit high.
- R10: If lock is not seen within `lock_timeout_us` ticks, the block ends with `done` and `err` and never writes normal mode, so the PLL is left in slow mode.
- R11: Requests arriving while `busy` is high are ignored: every write targets the PLL of the accepted request, and only one `done` follows.
- R12: `done` is a single-cycle pulse. `err` stays at its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_pll | input | 3 | Target PLL index 0..4 |
| req_nr | input | 7 | Reference divider NR |
| req_nf | input | 14 | Feedback multiplier NF |
| req_no | input | 5 | Output divider NO |
| lock_timeout_us | input | 16 | Lock wait limit in ticks |
| lock_status | input | 16 | Status word, lock of PLL i at bit 5+i |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Last request was rejected or timed out |
| cw_we | output | 1 | Control word write strobe |
| cw_pll | output | 3 | PLL targeted by the control write |
| cw_idx | output | 2 | Control word number 0..3 |
| cw_data | output | 16 | Control write data |
| cw_mask | output | 16 | Control write bit mask |
| mode_we | output | 1 | Mode word write strobe |
| mode_data | output | 16 | Mode write data |
| mode_mask | output | 16 | Mode write bit mask |

## Verification
The assertions check several properties on every cycle:
- `done` lasts one cycle.
- No write leaves the block while it is idle.
- The two write ports are never active together.
- No divisor word is written unless the reset bit was last written as set.
- The latched PLL index does not change during a request.
- `busy` rises only after a request.
- Normal mode is written only after lock was seen.

Only the bench scenarios can show the remaining behaviour:
- the exact write order and encodings for several PLLs and divisor sets;
- the boundary VCO and output limits;
- the exact hold length in ticks;
- the timeout path that leaves the PLL slow;
- the level behaviour of `err` across requests.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    localparam int NUM_PLL   = 5;
    localparam int PIDX_W    = 3;
    localparam int WORD_W    = 16;
    localparam int LOCK_BASE = 5;
    localparam int RST_BIT   = 5;
    localparam int NR_FLD    = 6;
    localparam int NF_FLD    = 13;
    localparam int NO_FLD    = 4;
    localparam int BW_FLD    = 12;
    localparam int NR_SHIFT  = 8;

    localparam logic [1:0] MODE_SLOW   = 2'd0;
    localparam logic [1:0] MODE_NORMAL = 2'd1;

    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_SLOW, S_RST_ON, S_WR_NR_NO, S_WR_NF, S_WR_BW,
        S_HOLD, S_RST_OFF, S_POLL, S_NORMAL, S_DONE, S_FAIL
    } seq_state_t;

    function automatic logic [3:0] mode_offset(input logic [PIDX_W-1:0] idx);
        if (idx == 3'd4) return 4'd14;
        return {idx[1:0], 2'b00};
    endfunction
endpackage

// File: rtl/pll_seq_limits.sv
module pll_seq_limits
    import pll_seq_pkg::*;
#(
    parameter int REF_KHZ     = 24000,
    parameter int VCO_MIN_KHZ = 440000,
    parameter int VCO_MAX_KHZ = 2200000,
    parameter int OUT_MIN_KHZ = 27500,
    parameter int OUT_MAX_KHZ = 2200000,
    parameter int NR_W        = 7,
    parameter int NF_W        = 14,
    parameter int NO_W        = 5
) (
    input  logic [PIDX_W-1:0] pll,
    input  logic [NR_W-1:0]   nr,
    input  logic [NF_W-1:0]   nf,
    input  logic [NO_W-1:0]   no,
    output logic              ok
);
    localparam int PW     = 48;
    localparam int NR_LIM = 1 << NR_FLD;
    localparam int NF_LIM = 1 << NF_FLD;
    localparam int NO_LIM = 1 << NO_FLD;

    logic [PW-1:0] vco_num, vco_lo, vco_hi, out_lo, out_hi;
    logic          range_ok, no_rule_ok, freq_ok;

    always_comb begin
        vco_num = PW'(REF_KHZ) * PW'(nf);
        vco_lo  = PW'(VCO_MIN_KHZ) * PW'(nr);
        vco_hi  = PW'(VCO_MAX_KHZ) * PW'(nr);
        out_lo  = PW'(OUT_MIN_KHZ) * PW'(nr) * PW'(no);
        out_hi  = PW'(OUT_MAX_KHZ) * PW'(nr) * PW'(no);
        range_ok = (int'(nr) >= 1) && (int'(nr) <= NR_LIM) &&
                   (int'(nf) >= 2) && (int'(nf) <= NF_LIM) &&
                   (int'(no) >= 1) && (int'(no) <= NO_LIM) &&
                   (int'(pll) < NUM_PLL);
        no_rule_ok = (no == NO_W'(1)) || (no[0] == 1'b0);
        freq_ok  = (vco_num >= vco_lo) && (vco_num <= vco_hi) &&
                   (vco_num >= out_lo) && (vco_num <= out_hi);
        ok = range_ok && no_rule_ok && freq_ok;
    end
endmodule

// File: rtl/pll_seq_us_timer.sv
module pll_seq_us_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [TMR_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 count <= '0;
        else if (clr)               count <= '0;
        else if (tick && (count != '1)) count <= count + 1'b1;
    end
endmodule

// File: rtl/pll_seq_fields.sv
module pll_seq_fields
    import pll_seq_pkg::*;
#(
    parameter int NR_W = 7,
    parameter int NF_W = 14,
    parameter int NO_W = 5
) (
    input  logic [NR_W-1:0]   nr,
    input  logic [NF_W-1:0]   nf,
    input  logic [NO_W-1:0]   no,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1,
    output logic [WORD_W-1:0] word2
);
    logic [NR_W-1:0] nr_m1;
    logic [NF_W-1:0] nf_m1, bw_val;
    logic [NO_W-1:0] no_m1;

    always_comb begin
        nr_m1  = nr - 1'b1;
        nf_m1  = nf - 1'b1;
        no_m1  = no - 1'b1;
        bw_val = (nf >> 1) - 1'b1;
        word0  = '0;
        word0[NR_SHIFT +: NR_FLD] = nr_m1[NR_FLD-1:0];
        word0[NO_FLD-1:0]         = no_m1[NO_FLD-1:0];
        word1  = '0;
        word1[NF_FLD-1:0]         = nf_m1[NF_FLD-1:0];
        word2  = '0;
        word2[BW_FLD-1:0]         = bw_val[BW_FLD-1:0];
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int REF_KHZ     = 24000,
    parameter int VCO_MIN_KHZ = 440000,
    parameter int VCO_MAX_KHZ = 2200000,
    parameter int OUT_MIN_KHZ = 27500,
    parameter int OUT_MAX_KHZ = 2200000,
    parameter int HOLD_US     = 10,
    parameter int TMR_W       = 16,
    parameter int NR_W        = 7,
    parameter int NF_W        = 14,
    parameter int NO_W        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              req_valid,
    input  logic [PIDX_W-1:0] req_pll,
    input  logic [NR_W-1:0]   req_nr,
    input  logic [NF_W-1:0]   req_nf,
    input  logic [NO_W-1:0]   req_no,
    input  logic [TMR_W-1:0]  lock_timeout_us,
    input  logic [WORD_W-1:0] lock_status,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              cw_we,
    output logic [PIDX_W-1:0] cw_pll,
    output logic [1:0]        cw_idx,
    output logic [WORD_W-1:0] cw_data,
    output logic [WORD_W-1:0] cw_mask,
    output logic              mode_we,
    output logic [WORD_W-1:0] mode_data,
    output logic [WORD_W-1:0] mode_mask
);
    localparam logic [WORD_W-1:0] RST_MASK  = WORD_W'(1) << RST_BIT;
    localparam logic [WORD_W-1:0] W0_MASK   = (WORD_W'((1 << NR_FLD) - 1) << NR_SHIFT) |
                                              WORD_W'((1 << NO_FLD) - 1);
    localparam logic [WORD_W-1:0] W1_MASK   = WORD_W'((1 << NF_FLD) - 1);
    localparam logic [WORD_W-1:0] W2_MASK   = WORD_W'((1 << BW_FLD) - 1);
    localparam logic [TMR_W-1:0]  HOLD_CNT  = TMR_W'(HOLD_US);

    seq_state_t        state, state_nx;
    logic [PIDX_W-1:0] pll_q;
    logic [NR_W-1:0]   nr_q;
    logic [NF_W-1:0]   nf_q;
    logic [NO_W-1:0]   no_q;
    logic              err_q;
    logic              req_ok;
    logic [TMR_W-1:0]  tcount;
    logic              tmr_clr;
    logic              lock_sel;
    logic [NUM_PLL-1:0] lock_vec;
    logic [WORD_W-1:0] word0, word1, word2;
    logic [3:0]        moff;

    pll_seq_limits #(
        .REF_KHZ(REF_KHZ), .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ),
        .OUT_MIN_KHZ(OUT_MIN_KHZ), .OUT_MAX_KHZ(OUT_MAX_KHZ),
        .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W)
    ) u_limits (
        .pll(pll_q), .nr(nr_q), .nf(nf_q), .no(no_q), .ok(req_ok)
    );

    pll_seq_fields #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W)) u_fields (
        .nr(nr_q), .nf(nf_q), .no(no_q),
        .word0(word0), .word1(word1), .word2(word2)
    );

    assign tmr_clr = !((state == S_HOLD) || (state == S_POLL));

    pll_seq_us_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(us_tick), .count(tcount)
    );

    assign lock_vec = lock_status[LOCK_BASE +: NUM_PLL];
    assign lock_sel = (int'(pll_q) < NUM_PLL) ? lock_vec[pll_q] : 1'b0;
    assign moff     = mode_offset(pll_q);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (req_valid) state_nx = S_CHECK;
            S_CHECK:    state_nx = req_ok ? S_SLOW : S_FAIL;
            S_SLOW:     state_nx = S_RST_ON;
            S_RST_ON:   state_nx = S_WR_NR_NO;
            S_WR_NR_NO: state_nx = S_WR_NF;
            S_WR_NF:    state_nx = S_WR_BW;
            S_WR_BW:    state_nx = S_HOLD;
            S_HOLD:     if (tcount >= HOLD_CNT) state_nx = S_RST_OFF;
            S_RST_OFF:  state_nx = S_POLL;
            S_POLL: begin
                if (lock_sel)                     state_nx = S_NORMAL;
                else if (tcount >= lock_timeout_us) state_nx = S_FAIL;
            end
            S_NORMAL:   state_nx = S_DONE;
            S_DONE:     state_nx = S_IDLE;
            S_FAIL:     state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            pll_q <= '0;
            nr_q  <= '0;
            nf_q  <= '0;
            no_q  <= '0;
            err_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && req_valid) begin
                pll_q <= req_pll;
                nr_q  <= req_nr;
                nf_q  <= req_nf;
                no_q  <= req_no;
                err_q <= 1'b0;
            end else if (state == S_FAIL) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        done      = 1'b0;
        err       = err_q;
        cw_we     = 1'b0;
        cw_pll    = pll_q;
        cw_idx    = 2'd0;
        cw_data   = '0;
        cw_mask   = '0;
        mode_we   = 1'b0;
        mode_data = '0;
        mode_mask = WORD_W'(2'b11) << moff;
        unique case (state)
            S_SLOW: begin
                mode_we   = 1'b1;
                mode_data = WORD_W'(MODE_SLOW) << moff;
            end
            S_RST_ON: begin
                cw_we   = 1'b1;
                cw_idx  = 2'd3;
                cw_data = RST_MASK;
                cw_mask = RST_MASK;
            end
            S_WR_NR_NO: begin
                cw_we   = 1'b1;
                cw_idx  = 2'd0;
                cw_data = word0;
                cw_mask = W0_MASK;
            end
            S_WR_NF: begin
                cw_we   = 1'b1;
                cw_idx  = 2'd1;
                cw_data = word1;
                cw_mask = W1_MASK;
            end
            S_WR_BW: begin
                cw_we   = 1'b1;
                cw_idx  = 2'd2;
                cw_data = word2;
                cw_mask = W2_MASK;
            end
            S_RST_OFF: begin
                cw_we   = 1'b1;
                cw_idx  = 2'd3;
                cw_data = '0;
                cw_mask = RST_MASK;
            end
            S_NORMAL: begin
                mode_we   = 1'b1;
                mode_data = WORD_W'(MODE_NORMAL) << moff;
            end
            S_DONE: done = 1'b1;
            S_FAIL: begin
                done = 1'b1;
                err  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk
    import pll_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [WORD_W-1:0] lock_status,
    input logic              busy,
    input logic              done,
    input logic              cw_we,
    input logic [PIDX_W-1:0] cw_pll,
    input logic [1:0]        cw_idx,
    input logic [WORD_W-1:0] cw_data,
    input logic              mode_we,
    input logic [WORD_W-1:0] mode_data
);
    logic rst_seen;
    logic lock_at;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_seen <= 1'b0;
        else if (cw_we && cw_idx == 2'd3) rst_seen <= cw_data[RST_BIT];
    end

    assign lock_at = lock_status[LOCK_BASE + int'(cw_pll)];

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(cw_we || mode_we));
    assert_one_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cw_we && mode_we));
    assert_div_under_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_we && cw_idx != 2'd3) |-> rst_seen);
    assert_pll_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cw_pll));
    assert_start_by_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    assert_normal_after_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && (mode_data != '0)) |-> $past(lock_at));
endmodule

bind pll_reprog_seq pll_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lock_status(lock_status),
    .busy(busy), .done(done), .cw_we(cw_we), .cw_pll(cw_pll), .cw_idx(cw_idx),
    .cw_data(cw_data), .mode_we(mode_we), .mode_data(mode_data)
);

// File: tb/sim_pll_reprog_seq.sv
`timescale 1ns/1ps
module sim_pll_reprog_seq;
    localparam int TICK_PER = 20;
    localparam int LOCK_DLY = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_pll = '0;
    logic [6:0]  req_nr = '0;
    logic [13:0] req_nf = '0;
    logic [4:0]  req_no = '0;
    logic [15:0] lock_timeout_us = 16'd50;
    logic [15:0] lock_status;
    logic        busy, done, err, cw_we, mode_we;
    logic [2:0]  cw_pll;
    logic [1:0]  cw_idx;
    logic [15:0] cw_data, cw_mask, mode_data, mode_mask;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    pll_reprog_seq u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req_valid(req_valid),
        .req_pll(req_pll), .req_nr(req_nr), .req_nf(req_nf), .req_no(req_no),
        .lock_timeout_us(lock_timeout_us), .lock_status(lock_status),
        .busy(busy), .done(done), .err(err), .cw_we(cw_we), .cw_pll(cw_pll),
        .cw_idx(cw_idx), .cw_data(cw_data), .cw_mask(cw_mask), .mode_we(mode_we),
        .mode_data(mode_data), .mode_mask(mode_mask)
    );

    always #2.5 clk = ~clk;

    // tick source
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv <= (tdiv == TICK_PER - 1) ? 0 : tdiv + 1;
        us_tick <= (tdiv == TICK_PER - 1);
    end

    // PLL lock model and write monitor
    logic [4:0] rst_m = '0, lk = '0, dead = '0;
    int lcnt [5];
    int lg_n = 0;
    bit lg_mode [16];
    int lg_pll [16];
    int lg_idx [16];
    logic [15:0] lg_data [16], lg_mask [16];
    int done_cnt = 0;
    bit last_err = 0;
    int hold_ph = 0, hold_ticks = 0;
    bit any_idle_write = 0;

    assign lock_status = {6'b0, lk, 5'b0};

    always @(negedge clk) begin
        if (hold_ph == 2 && us_tick) hold_ticks++;
        if (hold_ph == 1) hold_ph = 2;
        if (!busy && (cw_we || mode_we)) any_idle_write = 1;
        if (cw_we || mode_we) begin
            if (lg_n < 16) begin
                lg_mode[lg_n] = mode_we;
                lg_pll[lg_n]  = int'(cw_pll);
                lg_idx[lg_n]  = int'(cw_idx);
                lg_data[lg_n] = mode_we ? mode_data : cw_data;
                lg_mask[lg_n] = mode_we ? mode_mask : cw_mask;
            end
            lg_n++;
            if (cw_we && cw_idx == 2'd2) begin hold_ph = 1; hold_ticks = 0; end
            if (cw_we && cw_idx == 2'd3 && !cw_data[5]) hold_ph = 0;
            if (cw_we && cw_idx == 2'd3) rst_m[cw_pll] = cw_data[5];
        end
        if (done) begin done_cnt++; last_err = err; end
        for (int i = 0; i < 5; i++) begin
            if (rst_m[i] || dead[i]) begin lcnt[i] = 0; lk[i] <= 1'b0; end
            else if (lcnt[i] < LOCK_DLY) lcnt[i]++;
            else lk[i] <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input int p, input int nr, input int nf, input int no);
        @(negedge clk);
        lg_n = 0;
        req_pll = 3'(p); req_nr = 7'(nr); req_nf = 14'(nf); req_no = 5'(no);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int start, input int lim, output int cyc);
        cyc = 0;
        while (done_cnt == start && cyc < lim) begin @(negedge clk); cyc++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err, "R1 reset outputs", {busy, done, err}, 0);
        repeat (5) @(negedge clk);
        chk(lg_n == 0 && !any_idle_write, "R1 no writes idle", lg_n, 0);
    endtask

    task automatic t_good(input int p, input int nr, input int nf, input int no);
        int st, cyc, off;
        logic [15:0] w0, w1, w2;
        off = (p == 4) ? 14 : p * 4;
        w0 = 16'(((nr - 1) << 8) | (no - 1));
        w1 = 16'(nf - 1);
        w2 = 16'((nf / 2) - 1);
        st = done_cnt;
        send(p, nr, nf, no);
        wait_done(st, 2000, cyc);
        chk(done_cnt == st + 1 && !last_err, "R3 good request completes", last_err, 0);
        chk(lg_n == 7, "R3 write count", lg_n, 7);
        if (lg_n == 7) begin
            chk(lg_mode[0] && lg_data[0] == 16'h0 && lg_mask[0] == (16'h3 << off),
                "R4 mode slow field", lg_mask[0], 16'h3 << off);
            chk(!lg_mode[1] && lg_idx[1] == 3 && lg_data[1] == 16'h20 && lg_mask[1] == 16'h20,
                "R7 reset set first", lg_data[1], 16'h20);
            chk(!lg_mode[2] && lg_idx[2] == 0 && lg_data[2] == w0 && lg_mask[2] == 16'h3F0F,
                "R5 word0", lg_data[2], w0);
            chk(!lg_mode[3] && lg_idx[3] == 1 && lg_data[3] == w1 && lg_mask[3] == 16'h1FFF,
                "R5 word1", lg_data[3], w1);
            chk(!lg_mode[4] && lg_idx[4] == 2 && lg_data[4] == w2 && lg_mask[4] == 16'h0FFF,
                "R6 word2 bandwidth", lg_data[4], w2);
            chk(!lg_mode[5] && lg_idx[5] == 3 && lg_data[5] == 16'h0 && lg_mask[5] == 16'h20,
                "R7 reset cleared", lg_data[5], 0);
            chk(lg_mode[6] && lg_data[6] == (16'h1 << off) && lg_mask[6] == (16'h3 << off),
                "R4 R9 mode normal", lg_data[6], 16'h1 << off);
            for (int k = 1; k < 6; k++)
                chk(lg_pll[k] == p, "R3 target pll", lg_pll[k], p);
        end
        chk(hold_ticks == 10, "R8 hold ticks", hold_ticks, 10);
    endtask

    task automatic t_reject(input int p, input int nr, input int nf, input int no, input string why);
        int st, cyc;
        st = done_cnt;
        send(p, nr, nf, no);
        wait_done(st, 100, cyc);
        chk(done_cnt == st + 1 && last_err, {"R2 reject ", why}, last_err, 1);
        chk(cyc <= 2, {"R2 reject latency ", why}, cyc, 2);
        chk(lg_n == 0, {"R2 no writes ", why}, lg_n, 0);
        chk(err, "R12 err held", err, 1);
    endtask

    task automatic t_timeout();
        int st, cyc;
        dead[2] = 1'b1;
        lock_timeout_us = 16'd5;
        st = done_cnt;
        send(2, 1, 50, 2);
        wait_done(st, 2000, cyc);
        chk(done_cnt == st + 1 && last_err, "R10 timeout error", last_err, 1);
        chk(lg_n == 6, "R10 no normal-mode write", lg_n, 6);
        chk(err, "R12 err level after timeout", err, 1);
        dead[2] = 1'b0;
        lock_timeout_us = 16'd50;
    endtask

    task automatic t_busy_ignore();
        int st, cyc;
        bit stray;
        st = done_cnt;
        send(1, 2, 50, 2);
        repeat (30) @(negedge clk);
        req_pll = 3'd3; req_nr = 7'd1; req_nf = 14'd75; req_no = 5'd1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(st, 2000, cyc);
        repeat (20) @(negedge clk);
        stray = 0;
        for (int k = 0; k < lg_n && k < 16; k++)
            if (!lg_mode[k] && lg_pll[k] != 1) stray = 1;
        chk(!stray && lg_n == 7, "R11 writes only to accepted pll", lg_n, 7);
        chk(done_cnt == st + 1, "R11 single done", done_cnt - st, 1);
        chk(!busy, "R11 idle after", busy, 0);
    endtask

    // R12 done width check
    int done_run = 0, done_max = 0;
    always @(negedge clk) begin
        done_run = done ? done_run + 1 : 0;
        if (done_run > done_max) done_max = done_run;
    end

    initial begin
        for (int i = 0; i < 5; i++) lcnt[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_good(0, 1, 75, 1);
        t_good(4, 2, 50, 2);
        t_good(2, 3, 55, 16);
        t_good(3, 3, 275, 1);
        t_reject(1, 1, 75, 3, "odd NO");
        t_reject(1, 1, 10, 1, "VCO low");
        t_reject(1, 3, 276, 1, "VCO high");
        t_reject(1, 0, 50, 2, "NR zero");
        t_reject(5, 1, 75, 1, "bad index");
        t_good(1, 2, 50, 2);
        chk(!err, "R12 err cleared by new request", err, 0);
        t_timeout();
        t_busy_ignore();
        chk(done_max == 1, "R12 done single cycle", done_max, 1);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule